// File: doc/BRIEF.md
# Manchester Word Link Channel

This block is one channel of a half-duplex serial link that carries 16-bit words over a single line, Manchester coded at 16 clock samples per bit (1 Mbit/s from a 16 MHz clock). Every frame opens with a three-bit-period preamble and ends with an odd parity bit. The receive side watches the line for the preamble and recovers the bits. It checks the parity and places each decoded word in a receive FIFO. The host drains that FIFO through a pop interface.

The transmit side exists to test a receiver. The host loads a word into a transmit register and writes the go bit. The channel drives one frame, or two frames with a fixed quiet gap between them when repeat is enabled. It enables the line driver only while a frame is on the line. Because the two sides share the line, a channel can receive its own transmission as a loopback.

Top module: `mwl_channel`

## Requirements
- R1: The line idles low. A frame is 20 bit periods of SPB clocks each. Bit period 0 is high for the whole period, and periods 1 and 2 are low for their whole length. Periods 3..18 carry the data word, most significant bit first. Period 19 carries the parity bit. A data or parity bit b is driven as ~b for the first SPB/2 clocks and as b for the last SPB/2 clocks, so a 1 rises at mid-bit and a 0 falls at mid-bit.
- R2: The parity bit is chosen so that the 16 data bits plus the parity bit hold an odd number of ones.
- R3: Writing ctl_data bit 0 = 1 with ctl_we while the transmitter is idle starts a frame. From the next cycle, busy and line_oe are high and line_out is high. The word sent is the value of the transmit register at the go write. A go write while busy is ignored. The go bit is not stored.
- R4: line_oe is high only while a frame is being driven. line_out is low whenever line_oe is low.
- R5: When the repeat bit (ctl_data bit 1, stored at every ctl write and read back on ctl_rep) is set at the go write, the same word is sent twice. line_oe stays low for exactly GAP (default 192 clocks, 12 µs) between the two frames.
- R6: busy is high from the cycle after an accepted go until the cycle after the last frame's final clock.
- R7: Each correctly framed word that is received is stored in the receive FIFO in arrival order. rx_valid is high while the FIFO holds a word. rx_data shows the oldest word, and rx_pop removes it. rx_count gives the fill level.
- R8: A received word with wrong parity is still stored, and the sticky par_err flag is set. A ctl write with bit 2 = 1 clears it.
- R9: A word that arrives while the FIFO holds DEPTH words is dropped, and the sticky ovf flag is set. A ctl write with bit 3 = 1 clears it.
- R10: A frame is discarded and nothing is stored in either of two cases: the preamble is not high at mid-period 0 and low at mid-periods 1 and 2, or a data or parity bit shows the same level a quarter bit before and a quarter bit after mid-bit.
- R11: After reset, line_oe, line_out, busy, rx_valid, par_err, ovf and ctl_rep are 0, and rx_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, SPB per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Serial line as seen by the receiver |
| line_out | output | 1 | Serial line driven by the transmitter |
| line_oe | output | 1 | Line driver enable |
| txw_we | input | 1 | Write strobe for the transmit word register |
| txw_data | input | W | New transmit word |
| tx_word | output | W | Transmit word register readback |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 4 | bit0 go, bit1 repeat, bit2 clear parity error, bit3 clear overflow |
| ctl_rep | output | 1 | Stored repeat bit |
| busy | output | 1 | Transmission in progress |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_data | output | W | Oldest received word |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_count | output | $clog2(DEPTH)+1 | Receive FIFO fill level |
| par_err | output | 1 | Sticky parity error |
| ovf | output | 1 | Sticky receive overflow |

## Verification
A wrong bit counter or half-bit phase in the transmitter shows on line_out within the first frame, because the bench compares every one of the 320 samples with a waveform it computes itself. A receiver that is misaligned or has a bad shift register shows at rx_data a few cycles after the frame ends, either as a wrong word or as a missing word. Flag or FIFO pointer faults show as a wrong rx_count, par_err or ovf value when the bench inspects them after each frame. A gap counter that is off by one shows as a wrong count of low line_oe cycles between repeated frames.

// File: rtl/mwl_pkg.sv
package mwl_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_SYNC, RX_DATA} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GAP} tx_state_e;
    localparam int unsigned SYNC_BITS = 3;
endpackage

// File: rtl/mwl_rx.sv
module mwl_rx
    import mwl_pkg::*;
#(
    parameter int unsigned SPB = 16,
    parameter int unsigned W   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_in,
    output logic         word_valid,
    output logic [W-1:0] word_data,
    output logic         word_perr
);
    localparam int unsigned CW = $clog2(SPB);
    localparam int unsigned BW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(SPB - 1);
    localparam logic [CW-1:0] MID  = CW'(SPB / 2);
    localparam logic [CW-1:0] Q1   = CW'(SPB / 4);
    localparam logic [CW-1:0] Q3   = CW'((3 * SPB) / 4);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bidx;
        logic [W-1:0]  shreg;
        logic          first;
        logic          vout;
        logic [W-1:0]  wout;
        logic          pout;
    } rx_t;

    rx_t        d, q;
    logic [2:0] syn_q;
    logic       s, rise;

    assign s    = syn_q[1];
    assign rise = syn_q[1] & ~syn_q[2];

    always_comb begin
        d      = q;
        d.vout = 1'b0;
        d.cnt  = q.cnt + 1'b1;
        case (q.st)
            RX_IDLE: begin
                d.cnt = '0;
                if (rise) begin
                    d.st   = RX_SYNC;
                    d.cnt  = CW'(1);
                    d.bidx = '0;
                end
            end
            RX_SYNC: begin
                if (q.cnt == MID && s != (q.bidx == '0)) begin
                    d.st = RX_IDLE;
                end else if (q.cnt == LAST) begin
                    d.cnt = '0;
                    if (q.bidx == BW'(SYNC_BITS - 1)) begin
                        d.st   = RX_DATA;
                        d.bidx = '0;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (q.cnt == Q1) d.first = s;
                if (q.cnt == Q3) begin
                    if (s == q.first) begin
                        d.st = RX_IDLE;
                    end else if (q.bidx == BW'(W)) begin
                        d.vout = 1'b1;
                        d.wout = q.shreg;
                        d.pout = ~(^{q.shreg, s});
                        d.st   = RX_IDLE;
                    end else begin
                        d.shreg = {q.shreg[W-2:0], s};
                    end
                end
                if (q.cnt == LAST) begin
                    d.cnt  = '0;
                    d.bidx = q.bidx + 1'b1;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '{st: RX_IDLE, default: '0};
            syn_q <= '0;
        end else begin
            q     <= d;
            syn_q <= {syn_q[1:0], line_in};
        end
    end

    assign word_valid = q.vout;
    assign word_data  = q.wout;
    assign word_perr  = q.pout;
endmodule

// File: rtl/mwl_tx.sv
module mwl_tx
    import mwl_pkg::*;
#(
    parameter int unsigned SPB = 16,
    parameter int unsigned W   = 16,
    parameter int unsigned GAP = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         rep,
    input  logic [W-1:0] word,
    output logic         line,
    output logic         oe,
    output logic         busy
);
    localparam int unsigned FB = SYNC_BITS + W + 1;
    localparam int unsigned CW = $clog2(SPB);
    localparam int unsigned BW = $clog2(FB);
    localparam int unsigned GW = $clog2(GAP);
    localparam logic [CW-1:0] LAST = CW'(SPB - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bidx;
        logic [W:0]    frame;
        logic          again;
        logic [GW-1:0] gcnt;
    } tx_t;

    tx_t  d, q;
    logic bitv;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (go) begin
                    d.st    = TX_SEND;
                    d.cnt   = '0;
                    d.bidx  = '0;
                    d.frame = {word, ~(^word)};
                    d.again = rep;
                end
            end
            TX_SEND: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST) begin
                    d.cnt = '0;
                    if (q.bidx == BW'(FB - 1)) begin
                        d.st    = q.again ? TX_GAP : TX_IDLE;
                        d.again = 1'b0;
                        d.gcnt  = '0;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
            end
            TX_GAP: begin
                d.gcnt = q.gcnt + 1'b1;
                if (q.gcnt == GW'(GAP - 1)) begin
                    d.st   = TX_SEND;
                    d.cnt  = '0;
                    d.bidx = '0;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TX_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        bitv = 1'b0;
        line = 1'b0;
        if (q.st == TX_SEND) begin
            if (q.bidx == '0) begin
                line = 1'b1;
            end else if (q.bidx >= BW'(SYNC_BITS)) begin
                bitv = q.frame[BW'(W + SYNC_BITS) - q.bidx];
                line = (q.cnt >= CW'(SPB / 2)) ? bitv : ~bitv;
            end
        end
    end

    assign oe   = (q.st == TX_SEND);
    assign busy = (q.st != TX_IDLE);
endmodule

// File: rtl/mwl_fifo.sv
module mwl_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       valid,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, wp_d, rp_q, rp_d;

    assign count = wp_q - rp_q;
    assign valid = (count != '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign dout  = mem[rp_q[AW-1:0]];

    always_comb begin
        wp_d = wp_q + ((push && !full) ? 1'b1 : 1'b0);
        rp_d = rp_q + ((pop && valid) ? 1'b1 : 1'b0);
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp_q[AW-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            wp_q <= wp_d;
            rp_q <= rp_d;
        end
    end
endmodule

// File: rtl/mwl_channel.sv
module mwl_channel #(
    parameter int unsigned SPB   = 16,
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 512,
    parameter int unsigned GAP   = 192
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_in,
    output logic                   line_out,
    output logic                   line_oe,
    input  logic                   txw_we,
    input  logic [W-1:0]           txw_data,
    output logic [W-1:0]           tx_word,
    input  logic                   ctl_we,
    input  logic [3:0]             ctl_data,
    output logic                   ctl_rep,
    output logic                   busy,
    output logic                   rx_valid,
    output logic [W-1:0]           rx_data,
    input  logic                   rx_pop,
    output logic [$clog2(DEPTH):0] rx_count,
    output logic                   par_err,
    output logic                   ovf
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         rep;
        logic         perr;
        logic         ovf;
    } regs_t;

    regs_t        d, q;
    logic         go, rx_vld, rx_perr, f_full, push;
    logic [W-1:0] rx_word;

    assign go   = ctl_we & ctl_data[0];
    assign push = rx_vld & ~f_full;

    always_comb begin
        d = q;
        if (txw_we) d.word = txw_data;
        if (ctl_we) begin
            d.rep = ctl_data[1];
            if (ctl_data[2]) d.perr = 1'b0;
            if (ctl_data[3]) d.ovf  = 1'b0;
        end
        if (push && rx_perr)   d.perr = 1'b1;
        if (rx_vld && f_full)  d.ovf  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    mwl_tx #(.SPB(SPB), .W(W), .GAP(GAP)) u_tx (
        .clk(clk), .rst_n(rst_n), .go(go), .rep(ctl_data[1]), .word(q.word),
        .line(line_out), .oe(line_oe), .busy(busy)
    );

    mwl_rx #(.SPB(SPB), .W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .word_valid(rx_vld), .word_data(rx_word), .word_perr(rx_perr)
    );

    mwl_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(rx_word), .pop(rx_pop),
        .dout(rx_data), .valid(rx_valid), .full(f_full), .count(rx_count)
    );

    assign tx_word = q.word;
    assign ctl_rep = q.rep;
    assign par_err = q.perr;
    assign ovf     = q.ovf;
endmodule

// File: rtl/mwl_channel_chk.sv
module mwl_channel_chk #(
    parameter int unsigned DEPTH = 512
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   line_out,
    input logic                   line_oe,
    input logic                   ctl_we,
    input logic [3:0]             ctl_data,
    input logic                   busy,
    input logic                   rx_valid,
    input logic [$clog2(DEPTH):0] rx_count,
    input logic                   par_err,
    input logic                   ovf
);
    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !line_oe |-> !line_out); // R4
    AST_OE_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) line_oe |-> busy); // R6
    AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (ctl_we && ctl_data[0] && !busy) |=> (busy && line_oe && line_out)); // R3
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (par_err && !(ctl_we && ctl_data[2])) |=> par_err); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !(ctl_we && ctl_data[3])) |=> ovf); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= ($clog2(DEPTH)+1)'(DEPTH)); // R7
    AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n) rx_valid == (rx_count != '0)); // R7
endmodule

bind mwl_channel mwl_channel_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_out(line_out), .line_oe(line_oe),
    .ctl_we(ctl_we), .ctl_data(ctl_data), .busy(busy), .rx_valid(rx_valid),
    .rx_count(rx_count), .par_err(par_err), .ovf(ovf)
);

// File: tb/mwl_channel_test.sv
module mwl_channel_test;
    localparam int SPB = 16;
    localparam int W = 16;
    localparam int DEPTH = 4;
    localparam int GAP = 192;
    localparam int CNTW = $clog2(DEPTH) + 1;
    localparam int NVEC = 5;
    localparam logic [16:0] VEC [NVEC] = '{
        {16'hA5C3, 1'b0}, {16'h0000, 1'b1}, {16'hFFFF, 1'b0},
        {16'h8001, 1'b1}, {16'h1234, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic tb_line = 1'b0;
    logic line_in, line_out, line_oe, txw_we = 1'b0, ctl_we = 1'b0, ctl_rep, busy;
    logic rx_valid, rx_pop = 1'b0, par_err, ovf;
    logic [W-1:0] txw_data = '0, tx_word, rx_data;
    logic [3:0] ctl_data = '0;
    logic [CNTW-1:0] rx_count;
    int total = 0, bad = 0;

    always #10 clk = ~clk;
    assign line_in = line_oe ? line_out : tb_line;

    mwl_channel #(.SPB(SPB), .W(W), .DEPTH(DEPTH), .GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_out(line_out),
        .line_oe(line_oe), .txw_we(txw_we), .txw_data(txw_data), .tx_word(tx_word),
        .ctl_we(ctl_we), .ctl_data(ctl_data), .ctl_rep(ctl_rep), .busy(busy),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop), .rx_count(rx_count),
        .par_err(par_err), .ovf(ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [W-1:0] w);
        @(negedge clk); txw_we = 1'b1; txw_data = w;
        @(negedge clk); txw_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [3:0] c);
        @(negedge clk); ctl_we = 1'b1; ctl_data = c;
        @(negedge clk); ctl_we = 1'b0; ctl_data = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic pop_chk(input string req, input logic [W-1:0] exp);
        chk(req, {31'b0, rx_valid}, 32'd1);
        chk(req, {16'b0, rx_data}, {16'b0, exp});
        rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    function automatic logic exp_sample(input logic [W-1:0] w, input int s);
        int b = s / SPB;
        int ph = s % SPB;
        logic [16:0] fr = {w, ~(^w)};
        logic v;
        if (b == 0) return 1'b1;
        if (b < 3) return 1'b0;
        v = fr[16 - (b - 3)];
        return (ph < SPB / 2) ? ~v : v;
    endfunction

    // bench-built frame on tb_line; bad_sync stretches the first high period,
    // bad_bit >= 0 removes the mid-bit transition from that bit
    task automatic drive_frame(input logic [W-1:0] w, input logic p,
                               input bit bad_sync, input int bad_bit);
        logic [16:0] fr = {w, p};
        for (int s = 0; s < 20 * SPB; s++) begin
            int b = s / SPB;
            int ph = s % SPB;
            logic v;
            @(negedge clk);
            if (b == 0) tb_line = 1'b1;
            else if (b == 1) tb_line = bad_sync;
            else if (b == 2) tb_line = 1'b0;
            else begin
                v = fr[16 - (b - 3)];
                if (b - 3 == bad_bit) tb_line = v;
                else tb_line = (ph < SPB / 2) ? ~v : v;
            end
        end
        @(negedge clk); tb_line = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n1, ng, n2, mism;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 oe", {31'b0, line_oe}, 0);
        chk("R11 line", {31'b0, line_out}, 0);
        chk("R11 busy", {31'b0, busy}, 0);
        chk("R11 flags", {28'b0, rx_valid, par_err, ovf, ctl_rep}, 0);
        chk("R11 count", 32'(rx_count), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk: loopback of each word, single or repeated (R3 R5 R7 R2)
        foreach (VEC[i]) begin
            wr_word(VEC[i][16:1]);
            wr_ctl({2'b00, VEC[i][0], 1'b1});
            chk("R5 rep readback", {31'b0, ctl_rep}, {31'b0, VEC[i][0]});
            wait_idle();
            chk("R7 count", 32'(rx_count), VEC[i][0] ? 2 : 1);
            pop_chk("R7 word", VEC[i][16:1]);
            if (VEC[i][0]) pop_chk("R5 second word", VEC[i][16:1]);
            chk("R2 no parity error", {31'b0, par_err}, 0);
        end

        // R1 R2 exact waveform, R3 start timing, R5 gap, R6 busy span
        wr_word(16'h6B1E);
        @(negedge clk); ctl_we = 1'b1; ctl_data = 4'b0011;
        @(negedge clk); ctl_we = 1'b0; ctl_data = '0;
        chk("R3 busy after go", {31'b0, busy}, 1);
        mism = 0; n1 = 0; ng = 0; n2 = 0;
        while (line_oe) begin
            if (line_out !== exp_sample(16'h6B1E, n1)) mism++;
            n1++; @(negedge clk);
        end
        chk("R1 R2 waveform mismatches", 32'(mism), 0);
        chk("R1 frame length", 32'(n1), 20 * SPB);
        while (!line_oe && busy) begin
            if (line_out !== 1'b0) mism++;
            ng++; @(negedge clk);
        end
        chk("R5 gap cycles", 32'(ng), GAP);
        chk("R4 line low in gap", 32'(mism), 0);
        while (line_oe) begin n2++; @(negedge clk); end
        chk("R5 second frame length", 32'(n2), 20 * SPB);
        chk("R6 busy falls with last frame", {31'b0, busy}, 0);
        chk("R4 oe low after", {31'b0, line_oe}, 0);
        wait_idle();
        pop_chk("R7 first", 16'h6B1E);
        pop_chk("R7 second", 16'h6B1E);

        // R3 go while busy ignored, word latched at go
        wr_word(16'h00F0);
        wr_ctl(4'b0001);
        repeat (50) @(negedge clk);
        wr_word(16'h0F00);
        wr_ctl(4'b0001);
        wait_idle();
        chk("R3 one frame only", 32'(rx_count), 1);
        pop_chk("R3 latched word", 16'h00F0);
        chk("R3 register readback", {16'b0, tx_word}, 32'h0F00);

        // R7 bench-driven correct frame, R8 bad parity
        drive_frame(16'hC3A5, ~(^16'hC3A5), 1'b0, -1);
        chk("R8 good parity clean", {31'b0, par_err}, 0);
        pop_chk("R7 driven word", 16'hC3A5);
        drive_frame(16'h5A01, ^16'h5A01, 1'b0, -1);
        chk("R8 flag set", {31'b0, par_err}, 1);
        pop_chk("R8 word still stored", 16'h5A01);
        wr_ctl(4'b0100);
        chk("R8 flag cleared", {31'b0, par_err}, 0);

        // R10 framing faults
        drive_frame(16'h0000, 1'b1, 1'b1, -1);
        chk("R10 bad sync dropped", 32'(rx_count), 0);
        drive_frame(16'h0000, 1'b1, 1'b0, 5);
        chk("R10 missing transition dropped", 32'(rx_count), 0);
        chk("R10 no flags", {30'b0, par_err, ovf}, 0);

        // R9 overflow
        for (int k = 0; k < DEPTH + 1; k++) begin
            wr_word(16'h1000 + 16'(k));
            wr_ctl(4'b0001);
            wait_idle();
        end
        chk("R9 count full", 32'(rx_count), DEPTH);
        chk("R9 ovf set", {31'b0, ovf}, 1);
        for (int k = 0; k < DEPTH; k++) pop_chk("R9 order kept", 16'h1000 + 16'(k));
        chk("R9 extra dropped", {31'b0, rx_valid}, 0);
        wr_ctl(4'b1000);
        chk("R9 ovf cleared", {31'b0, ovf}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule